// File: doc/BRIEF.md
# Bit-Serial Partial-Product Recombiner

This block turns a stream of digitized column sums into signed 8-bit by 8-bit dot-product results. Each signed weight sits in the array as two unsigned magnitudes, one for positive values and one for negative values, and only one of the two is nonzero. Each magnitude is cut into 2-bit slices. The input vector is applied one bit plane at a time. Every step of the schedule therefore gives two unsigned partial sums: one from the positive column and one from the negative column. Both come from one input bit acting on one weight slice.

The block subtracts the negative sum from the positive sum. It shifts the difference left by the bit position of that step and adds it to a signed accumulator. A start pulse arms the block. Each step is accepted only while the input valid is high, so a producer can stall between steps. After the last of the 32 steps, a done pulse marks the final signed result. The result stays on the output until the next start.

Top module: `bsp_recombiner`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `result_o` is 0.
- R2: A start pulse seen while idle clears the accumulator and the schedule position, so `result_o` reads 0 on the cycle after that start.
- R3: Step k (k = 0..31) has input bit i = k/4 and weight slice j = k%4. The slice index advances fastest and the input bit runs from least to most significant. The step adds (`pos_sum_i` − `neg_sum_i`) × 2^(i+2j) to the accumulator, so the last step carries a weight of 2^13. `result_o` shows the running sum on the cycle after each accepted step.
- R4: While an operation is running, a cycle with `in_valid_i` low leaves both the accumulator and the schedule position unchanged, whatever values the sum inputs carry.
- R5: `done_o` is high for exactly one cycle: the cycle after the 32nd accepted step. In that cycle `result_o` holds the complete signed dot product, and the block is idle again.
- R6: A start pulse that arrives while an operation is running is ignored. A step accepted in the same cycle still counts, and the result is unaffected.
- R7: While idle, `in_valid_i` has no effect. `result_o` keeps its value and `done_o` stays low.
- R8: The accumulator holds the extremes without overflow. Each column sum may be 0..75, so 32 steps of 75 in one column give +1,625,625 or −1,625,625.
- R9: A start accepted in the same cycle that `done_o` is high begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; clears the accumulator and the schedule when idle |
| in_valid_i | input | 1 | The sum inputs carry a step |
| pos_sum_i | input | 7 | Unsigned partial sum from the positive-weight column |
| neg_sum_i | input | 7 | Unsigned partial sum from the negative-weight column |
| done_o | output | 1 | One-cycle pulse after the final step |
| result_o | output | 24 | Signed accumulator value |

## Verification
The bench goes after the ordering of the schedule by placing a single unit sum at step 1, step 4 or step 31. These steps expect 4, −2 and 8192. A design that swapped the fastest index, or got the last shift wrong, would give 2, −16 or a truncated value. Stalls are inserted with garbage on the sum inputs. A design that advanced or accumulated on an idle valid would drift away from the running sum that the bench checks after every step. A start is injected in the middle of an operation together with a valid step, and a start is issued in the very cycle of done. A block that restarted on the first would lose its partial sum, and one that missed the second would never finish. All-75 runs on each column check the extremes for overflow, and valid pulses while idle must leave the held result alone.

// File: rtl/bsp_recomb_pkg.sv
package bsp_recomb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rc_state_e;

  function automatic int shift_span(input int in_bits, input int slices, input int slice_bits);
    return (in_bits - 1) + slice_bits * (slices - 1) + 1;
  endfunction
endpackage

// File: rtl/bsp_sched.sv
module bsp_sched #(
  parameter int IN_BITS    = 8,
  parameter int SLICES     = 4,
  parameter int SLICE_BITS = 2,
  parameter int BIT_W      = $clog2(IN_BITS),
  parameter int SL_W       = $clog2(SLICES),
  parameter int SH_W       = $clog2(bsp_recomb_pkg::shift_span(IN_BITS, SLICES, SLICE_BITS))
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            step_i,
  output logic [SH_W-1:0] shamt_o,
  output logic            last_o
);
  logic [BIT_W-1:0] bit_q;
  logic [SL_W-1:0]  slice_q;
  logic             slice_wrap;

  assign slice_wrap = (slice_q == SL_W'(SLICES - 1));
  assign last_o     = slice_wrap && (bit_q == BIT_W'(IN_BITS - 1));
  assign shamt_o    = SH_W'(bit_q) + SH_W'(SLICE_BITS) * SH_W'(slice_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      slice_q <= '0;
    end else if (clear_i) begin
      bit_q   <= '0;
      slice_q <= '0;
    end else if (step_i) begin
      if (slice_wrap) begin
        slice_q <= '0;
        bit_q   <= last_o ? '0 : bit_q + 1'b1;
      end else begin
        slice_q <= slice_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsp_term.sv
module bsp_term #(
  parameter int PS_W  = 7,
  parameter int ACC_W = 24,
  parameter int SH_W  = 4
) (
  input  logic [PS_W-1:0]         pos_i,
  input  logic [PS_W-1:0]         neg_i,
  input  logic [SH_W-1:0]         shamt_i,
  output logic signed [ACC_W-1:0] term_o
);
  logic signed [PS_W:0]    diff;
  logic signed [ACC_W-1:0] diff_ext;

  assign diff     = $signed({1'b0, pos_i}) - $signed({1'b0, neg_i});
  assign diff_ext = ACC_W'(diff);
  assign term_o   = diff_ext <<< shamt_i;
endmodule

// File: rtl/bsp_acc.sv
module bsp_acc #(
  parameter int ACC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    add_i,
  input  logic signed [ACC_W-1:0] term_i,
  output logic signed [ACC_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clear_i) acc_o <= '0;
    else if (add_i)   acc_o <= acc_o + term_i;
  end
endmodule

// File: rtl/bsp_recombiner.sv
module bsp_recombiner #(
  parameter int IN_BITS    = 8,
  parameter int SLICES     = 4,
  parameter int SLICE_BITS = 2,
  parameter int PS_W       = 7,
  parameter int ACC_W      = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    in_valid_i,
  input  logic [PS_W-1:0]         pos_sum_i,
  input  logic [PS_W-1:0]         neg_sum_i,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] result_o
);
  import bsp_recomb_pkg::*;

  localparam int SH_W = $clog2(shift_span(IN_BITS, SLICES, SLICE_BITS));

  rc_state_e               state_q;
  logic                    busy_q;
  logic                    done_q;
  logic                    accept_start;
  logic                    step;
  logic                    last;
  logic [SH_W-1:0]         shamt;
  logic signed [ACC_W-1:0] term;

  assign busy_q       = (state_q == ST_RUN);
  assign accept_start = start_i && !busy_q;
  assign step         = busy_q && in_valid_i;

  bsp_sched #(
    .IN_BITS(IN_BITS), .SLICES(SLICES), .SLICE_BITS(SLICE_BITS), .SH_W(SH_W)
  ) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept_start), .step_i(step),
    .shamt_o(shamt), .last_o(last)
  );

  bsp_term #(.PS_W(PS_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_term (
    .pos_i(pos_sum_i), .neg_i(neg_sum_i), .shamt_i(shamt), .term_o(term)
  );

  bsp_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept_start), .add_i(step),
    .term_i(term), .acc_o(result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= step && last;
      if (accept_start)      state_q <= ST_RUN;
      else if (step && last) state_q <= ST_IDLE;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/bsp_recombiner_chk.sv
module bsp_recombiner_chk #(
  parameter int ACC_W = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    in_valid_i,
  input logic                    busy_q,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] result_o
);
  p_clear_on_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (result_o == '0 && busy_q));

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !in_valid_i) |=> $stable(result_o));

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q);

  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (busy_q || done_o));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(result_o) && !done_o));
endmodule

bind bsp_recombiner bsp_recombiner_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .in_valid_i(in_valid_i),
  .busy_q(busy_q), .done_o(done_o), .result_o(result_o)
);

// File: tb/bsp_recombiner_bench.sv
module bsp_recombiner_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vld = 1'b0;
  logic [6:0] ps = '0;
  logic [6:0] ns = '0;
  logic done;
  logic signed [23:0] res;

  int checks = 0;
  int errors = 0;
  logic signed [23:0] exp_q[$];
  logic prev_done = 1'b0;

  always #4 clk = ~clk;

  bsp_recombiner u_bsp_recombiner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(vld),
    .pos_sum_i(ps), .neg_sum_i(ns), .done_o(done), .result_o(res)
  );

  task automatic chk(input string req, input logic signed [31:0] act, input logic signed [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pval(input int mode, input int k);
    case (mode)
      0: return 1;
      1: return 75;
      3: return (k * 37 + 11) % 76;
      4: return (k == 31) ? 1 : 0;
      5: return (k == 1) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int nval(input int mode, input int k);
    case (mode)
      2: return 75;
      3: return (k * 53 + 5) % 76;
      6: return (k == 4) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // R3 schedule: slice fastest, bit LSB first, weight 2^(bit + 2*slice)
  function automatic int step_w(input int k);
    return 1 << ((k / 4) + 2 * (k % 4));
  endfunction

  // monitor: R5 scoreboard compare and pulse width
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected done", 1, 0);
        end else begin
          logic signed [23:0] e;
          e = exp_q.pop_front();
          chk("R5 final result", res, e);
        end
        if (prev_done) chk("R5 done width", 2, 1);
      end
      prev_done <= done;
    end
  end

  task automatic run_op(input int mode, input int stall_every, input bit mid_start, input bit at_done);
    int run = 0;
    int total = 0;
    for (int k = 0; k < 32; k++) total += (pval(mode, k) - nval(mode, k)) * step_w(k);
    exp_q.push_back(24'(total));
    if (!at_done) @(posedge clk);
    #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R2 clear after start", res, 0);
    if (at_done) chk("R9 busy restart", done, 0);
    for (int k = 0; k < 32; k++) begin
      if (stall_every != 0 && k % stall_every == 0) begin
        vld = 1'b0; ps = 7'd99; ns = 7'd13;
        @(posedge clk); @(posedge clk); #1;
        chk("R4 stall hold", res, run);
      end
      vld = 1'b1;
      ps = 7'(pval(mode, k));
      ns = 7'(nval(mode, k));
      start = (mid_start && k == 10);
      @(posedge clk); #1;
      vld = 1'b0; start = 1'b0;
      run += (pval(mode, k) - nval(mode, k)) * step_w(k);
      chk(mode == 1 || mode == 2 ? "R8 running sum" : (mid_start ? "R6 running sum" : "R3 running sum"), res, run);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", done, 0);
    chk("R1 reset result", res, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", res, 0);

    run_op(0, 0, 1'b0, 1'b0);
    run_op(5, 0, 1'b0, 1'b0);
    run_op(6, 0, 1'b0, 1'b0);
    run_op(4, 0, 1'b0, 1'b0);
    run_op(1, 0, 1'b0, 1'b0);
    run_op(2, 0, 1'b0, 1'b0);
    run_op(3, 3, 1'b0, 1'b0);
    run_op(3, 0, 1'b1, 1'b0);
    // start in the done cycle
    run_op(0, 5, 1'b0, 1'b1);
    @(posedge clk); #1;

    // R7: valid while idle
    begin
      logic signed [23:0] held;
      held = res;
      chk("R9 result held", held, 21675);
      vld = 1'b1; ps = 7'd50; ns = 7'd3;
      repeat (4) @(posedge clk);
      #1;
      vld = 1'b0;
      chk("R7 idle valid result", res, held);
      chk("R7 idle valid done", done, 0);
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R5 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule